// File: doc/BRIEF.md
# Repeated-Addition Serial Multiplier

This block multiplies two small unsigned integers by counting. A pulse on `start` captures the multiplier and the multiplicand into holding registers and zeroes an accumulator and an addition counter. After that, each clock adds the multiplicand, zero-extended to the product width, into the accumulator. The counter advances by one for each addition. An equality comparator watches the counter against the captured multiplier. When the two match, the clock enable of both the accumulator and the counter falls, the accumulator holds the product, and `done` goes high.

A job therefore takes as many clock cycles as the value of the multiplier, between none and fifteen with the default 4-bit operands. The result stays on `product` with `done` high until the next `start` or a reset. A new `start` may be given at any time and abandons the job in progress.

Top module: `rep_add_mul`

## Requirements
- R1: After reset, `done` is 0 and `product` is 0 until the first `start`.
- R2: The clock edge that samples `start` high zeroes the accumulator and the counter and captures `a_in` and `b_in`. This also applies while a job is still running, and the new job replaces the old one.
- R3: While the counter differs from the captured multiplier, every clock adds the zero-extended multiplicand once into the accumulator and increments the counter. At every cycle of a job the accumulator equals the counter times the multiplicand.
- R4: `done` rises exactly A clock edges after the edge that sampled `start`. For A = 0, `done` is already high after the start edge and `product` is 0.
- R5: When `done` is high, `product` equals A*B for all 256 operand pairs.
- R6: Once `done` is high, `product` and `done` stay constant until the next `start` or reset.
- R7: Changes on `a_in` and `b_in` after the start edge have no effect on the running job or on the held result.
- R8: The accumulator is 2*W bits wide and never overflows: no addition produces a carry out of it.
- R9: The counter never passes the captured multiplier and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request that captures the operands and begins a job |
| a_in | input | W (4) | Multiplier: the number of additions |
| b_in | input | W (4) | Multiplicand: the value added each cycle |
| product | output | 2*W (8) | Accumulator value; this is the product while `done` is high |
| done | output | 1 | High when the counter equals the captured multiplier |

## Verification
The bench covers the whole operand space and checks the result and the exact cycle count of every job.

| Corner case | What a faulty design would do |
|---|---|
| A = 0 (the zero-cycle job) | Report one cycle late, or leave a stale sum from the previous job. |
| 15 x 15 (the largest product) | Show any loss of accumulator width as a truncated product. |
| Operand inputs change during a job | Show a design that reads `a_in` or `b_in` directly, through a wrong stop point or a wrong addend. |
| `start` arrives in the middle of a long job | Show an incomplete clear as a leftover partial sum. |
| Reset arrives in the middle of a long job | Show an incomplete clear as a leftover partial sum. |
| The idle cycles after `done` | Show an enable that was not cut off as a product that keeps rising. |

// File: rtl/rep_add_pkg.sv
package rep_add_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_e;
endpackage

// File: rtl/rep_add_counter.sv
module rep_add_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ce,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (ce)    q <= q + W'(1);
  end

  // R9
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && !clr) |-> (q != {W{1'b1}}));
endmodule

// File: rtl/rep_add_eq.sv
module rep_add_eq #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic         match
);
  always_comb match = (x == y);
endmodule

// File: rtl/rep_add_accum.sv
module rep_add_accum #(
  parameter int W  = 4,
  parameter int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          ce,
  input  logic [W-1:0]  addend,
  output logic [PW-1:0] acc
);
  localparam int SW = PW + 1;

  logic [SW-1:0] sum;

  always_comb sum = {1'b0, acc} + {{(SW-W){1'b0}}, addend};

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (ce)    acc <= sum[PW-1:0];
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (ce && !clr) |-> !sum[PW]);
endmodule

// File: rtl/rep_add_mul.sv
module rep_add_mul
  import rep_add_pkg::*;
#(
  parameter int W  = 4,
  parameter int PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  a_in,
  input  logic [W-1:0]  b_in,
  output logic [PW-1:0] product,
  output logic          done
);
  run_state_e   state;
  logic [W-1:0] a_q, b_q;
  logic [W-1:0] cnt;
  logic [PW-1:0] acc;
  logic         at_limit;
  logic         step_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      a_q   <= '0;
      b_q   <= '0;
    end else if (start) begin
      state <= ST_RUN;
      a_q   <= a_in;
      b_q   <= b_in;
    end
  end

  rep_add_eq #(.W(W)) u_eq (
    .x     (cnt),
    .y     (a_q),
    .match (at_limit)
  );

  always_comb step_en = (state == ST_RUN) && !at_limit && !start;

  rep_add_counter #(.W(W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (start),
    .ce  (step_en),
    .q   (cnt)
  );

  rep_add_accum #(.W(W), .PW(PW)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .clr    (start),
    .ce     (step_en),
    .addend (b_q),
    .acc    (acc)
  );

  assign product = acc;
  assign done    = (state == ST_RUN) && at_limit;

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt == '0 && acc == '0 && a_q == $past(a_in) && b_q == $past(b_in)));

  // R3
  acc_tracks_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (acc == PW'(PW'(cnt) * PW'(b_q))));

  // R9
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (cnt <= a_q));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(product)));
endmodule

// File: tb/tb_rep_add_mul.sv
module tb_rep_add_mul;
  localparam int W  = 4;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [W-1:0]  a_in, b_in;
  logic [PW-1:0] product;
  logic          done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rep_add_mul #(.W(W), .PW(PW)) dut (
    .clk(clk), .rst(rst), .start(start),
    .a_in(a_in), .b_in(b_in), .product(product), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic launch(input int av, input int bv);
    @(negedge clk);
    a_in  = W'(av);
    b_in  = W'(bv);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Waits for done; returns the edges counted after the start edge.
  task automatic wait_done(output int cycles);
    cycles = 0;
    while (!done && cycles < 40) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic test_reset();
    rst = 1'b1; start = 1'b0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    chk(product == '0, "R1 product after reset", int'(product), 0);
  endtask

  task automatic test_sweep();
    for (int av = 0; av < 16; av++) begin
      for (int bv = 0; bv < 16; bv++) begin
        int cyc;
        launch(av, bv);
        wait_done(cyc);
        chk(cyc == av, "R4 cycle count", cyc, av);
        chk(int'(product) == av * bv, "R5 product (R3, R8)", int'(product), av * bv);
      end
    end
  endtask

  task automatic test_zero_after_big();
    int cyc;
    launch(15, 15);
    wait_done(cyc);
    launch(0, 9);
    chk(done == 1'b1, "R4 A=0 done at once", int'(done), 1);
    chk(product == '0, "R4 A=0 product zero", int'(product), 0);
  endtask

  task automatic test_hold();
    int cyc;
    launch(6, 11);
    wait_done(cyc);
    a_in = 4'd3; b_in = 4'd2;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(done == 1'b1, "R6 done held", int'(done), 1);
      chk(int'(product) == 66, "R6 product held", int'(product), 66);
    end
  endtask

  task automatic test_operand_change();
    int cyc;
    launch(5, 7);
    a_in = 4'd1; b_in = 4'd1;
    @(negedge clk);
    a_in = 4'd15; b_in = 4'd15;
    wait_done(cyc);
    chk(cyc == 4, "R7 stop point uses captured A", cyc, 4);
    chk(int'(product) == 35, "R7 addend uses captured B", int'(product), 35);
  endtask

  task automatic test_restart();
    int cyc;
    launch(15, 15);
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R3 busy mid job", int'(done), 0);
    launch(2, 3);
    wait_done(cyc);
    chk(cyc == 2, "R2 restart cycle count", cyc, 2);
    chk(int'(product) == 6, "R2 restart product", int'(product), 6);
  endtask

  task automatic test_reset_mid();
    launch(12, 13);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R1 done after mid reset", int'(done), 0);
    chk(product == '0, "R1 product after mid reset", int'(product), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R4 actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_sweep();
    test_zero_after_big();
    test_hold();
    test_operand_change();
    test_restart();
    test_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule